// File: doc/BRIEF.md
# Master-Mode Serial Audio Clock Generator

This block drives the bit clock and the left/right frame clock of a serial audio port while the chip is the port master. Both clocks come from the system clock. A 4-bit selector picks the bit clock ratio from a fixed set of sixteen divisors, some of them half-integers. An 11-bit length field gives the number of bit clocks in each frame. The frame clock follows that length field only and is not locked to any converter sample rate.

Edges are placed with half-system-clock resolution. Each system clock cycle is split into two slots: one while the system clock is high and one while it is low. Registered slot values are steered to the pins by the level of the system clock. This lets the /1, /1.5 and /5.5 ratios run at their exact periods.

When the master enable is low, both outputs stay low and every counter returns to its start state. Raising the enable starts a clean bit clock high phase and a frame clock that is low until the first bit clock falling edge.

Top module: `mcg_master_clkgen`

## Requirements
- R1: While reset is asserted or the master enable is low, both clocks are low and all counters are cleared. In the half-cycle (system clock high) right after the enable is first sampled high, the bit clock is high and the frame clock is low.
- R2: The ratio selector sets the bit clock period, in system clock periods, from this table: 0→1, 1→1.5, 2→2, 3→3, 4→4, 5→5.5, 6→6, 7→8, 8→11, 9→12, 10→16, 11→22, 12→24, 13→32, 14→44, 15→48.
- R3: Each bit clock period is T = 2×ratio system clock half-cycles long. It is high for the first ⌊T/2⌋ half-cycles and low for the rest. So /1.5 is high for one half-cycle and low for two, and /5.5 is high for five and low for six.
- R4: For a frame length L from 2 to 2047, the frame clock period is exactly L bit clock periods, whatever the ratio selector holds.
- R5: Within each frame the frame clock is high for ⌊L/2⌋ bit periods and then low for the remaining ones. An odd L gives the extra bit period to the low phase.
- R6: The frame clock changes level only in the half-cycle where the bit clock falls.
- R7: After enable, the frame clock stays low until the first bit clock falling edge. The first high phase of the frame clock starts at that edge.
- R8: A frame length of 0 or 1 holds the frame clock low, and the bit clock keeps running at its selected ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all registers use its rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| master_en_i | input | 1 | Master-mode enable; low holds both outputs low |
| bclk_sel_i | input | 4 | Bit clock ratio selector (see R2) |
| frame_len_i | input | 11 | Bit clocks per frame |
| bclk_o | output | 1 | Bit clock output |
| lrclk_o | output | 1 | Left/right frame clock output |

## Verification
A wrong slot counter shows at the bit clock pin within one bit clock period, as a stretched or shortened high or low phase. A corrupted frame index or start flag shows at the frame clock within one frame: the high phase lands at the wrong bit, an odd length splits the wrong way, or the frame clock moves in a half-cycle where the bit clock does not fall. The bench compares every half-cycle of both pins against a model built from the ratio table and the frame rules, so each fault shows up at the first half-cycle where it differs.

// File: rtl/mcg_pkg.sv
`timescale 1ns/1ps
// Shared constants and the ratio lookup for the master clock generator.
// Assumes: periods are counted in half system clock cycles, so every
// half-integer ratio turns into a whole count.
package mcg_pkg;

    localparam int CODE_W = 4;   // width of the bit clock ratio selector
    localparam int HP_W   = 7;   // width of a period counted in half-cycles

    // Map a ratio selector to the bit clock period in system clock half-cycles.
    function automatic logic [HP_W-1:0] half_period(input logic [CODE_W-1:0] sel);
        logic [HP_W-1:0] hp;
        case (sel)
            4'd0:    hp = 7'd2;
            4'd1:    hp = 7'd3;
            4'd2:    hp = 7'd4;
            4'd3:    hp = 7'd6;
            4'd4:    hp = 7'd8;
            4'd5:    hp = 7'd11;
            4'd6:    hp = 7'd12;
            4'd7:    hp = 7'd16;
            4'd8:    hp = 7'd22;
            4'd9:    hp = 7'd24;
            4'd10:   hp = 7'd32;
            4'd11:   hp = 7'd44;
            4'd12:   hp = 7'd48;
            4'd13:   hp = 7'd64;
            4'd14:   hp = 7'd88;
            default: hp = 7'd96;
        endcase
        return hp;
    endfunction

endpackage

// File: rtl/mcg_bit_phase.sv
`timescale 1ns/1ps
// Half-cycle phase counter for the bit clock.
// Each system clock cycle covers two slots: slot 0 (clock high) and
// slot 1 (clock low). For both slots this module reports the bit clock
// level and whether a falling edge starts there.
// Assumes: period_i >= 2, so there is at most one falling edge per cycle.
module mcg_bit_phase
    import mcg_pkg::*;
#(
    parameter int PW = HP_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic [PW-1:0] period_i,
    output logic          slot0_hi_o,
    output logic          slot1_hi_o,
    output logic          fall0_o,
    output logic          fall1_o
);

    logic [PW-1:0] pos_q;
    logic [PW-1:0] pos0;
    logic [PW-1:0] pos1;
    logic [PW-1:0] pos_next;
    logic [PW-1:0] hi_len;

    // Advance a slot position with wrap; also recovers if the period shrinks.
    function automatic logic [PW-1:0] step_pos(input logic [PW-1:0] p,
                                               input logic [PW-1:0] per);
        return (p >= per - PW'(1)) ? '0 : p + PW'(1);
    endfunction

    // Slot positions, levels and falling-edge flags for the coming cycle.
    always_comb begin
        hi_len     = period_i >> 1;
        pos0       = pos_q;
        pos1       = step_pos(pos0, period_i);
        pos_next   = step_pos(pos1, period_i);
        slot0_hi_o = (pos0 < hi_len);
        slot1_hi_o = (pos1 < hi_len);
        fall0_o    = (pos0 == hi_len);
        fall1_o    = (pos1 == hi_len);
    end

    // Hold the slot-0 position of the next cycle; cleared when not running.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_next;
        end
    end

    // R3: with a steady period the position stays inside the period.
    a_r3_pos_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && $stable(period_i)) |-> (pos_q < period_i));

    // R6: never two bit clock falling edges in one system clock cycle.
    a_r6_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> !(fall0_o && fall1_o));

endmodule

// File: rtl/mcg_frame_track.sv
`timescale 1ns/1ps
// Frame position tracker for the left/right clock.
// Advances one bit index at each bit clock falling edge reported for the
// two slots of a cycle, and gives the frame clock level of each slot.
// Assumes: at most one of fall0_i / fall1_i is set in a cycle.
module mcg_frame_track #(
    parameter int FW = 11
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic [FW-1:0] len_i,
    input  logic          fall0_i,
    input  logic          fall1_i,
    output logic          lr0_o,
    output logic          lr1_o
);

    typedef struct packed {
        logic          live;   // a bit clock falling edge has been seen
        logic [FW-1:0] idx;    // bit index inside the frame
    } frame_st_t;

    frame_st_t st_q;
    frame_st_t st0;
    frame_st_t st1;
    logic      len_ok;
    logic [FW-1:0] half_len;

    // Move the frame state on by one bit period.
    function automatic frame_st_t step_st(input frame_st_t s,
                                          input logic [FW-1:0] len);
        frame_st_t n;
        n.live = 1'b1;
        if (!s.live || (s.idx >= len - FW'(1))) begin
            n.idx = '0;
        end else begin
            n.idx = s.idx + FW'(1);
        end
        return n;
    endfunction

    // Frame state after slot 0 and after slot 1, and the matching levels.
    always_comb begin
        len_ok   = (len_i >= FW'(2));
        half_len = len_i >> 1;
        st0      = fall0_i ? step_st(st_q, len_i) : st_q;
        st1      = fall1_i ? step_st(st0, len_i) : st0;
        lr0_o    = st0.live && len_ok && (st0.idx < half_len);
        lr1_o    = st1.live && len_ok && (st1.idx < half_len);
    end

    // Keep the state reached at the end of the cycle; cleared when not running.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) begin
            st_q <= '0;
        end else begin
            st_q <= st1;
        end
    end

    // R7: the frame clock is never high before the first falling edge.
    a_r7_low_before_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !st_q.live && !fall0_i) |-> !lr0_o);

endmodule

// File: rtl/mcg_master_clkgen.sv
`timescale 1ns/1ps
// Master-mode bit clock and frame clock generator (top).
// Registers the slot-0 and slot-1 levels of both clocks at each system
// clock rising edge. It drives slot 0 while the system clock is high and
// slot 1 while it is low, which gives half-cycle edge placement.
// Assumes: inputs are synchronous to clk_i; outputs feed pads or a
// consumer that accepts a clock-level-steered waveform.
module mcg_master_clkgen
    import mcg_pkg::*;
#(
    parameter int FRAME_W = 11
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               master_en_i,
    input  logic [CODE_W-1:0]  bclk_sel_i,
    input  logic [FRAME_W-1:0] frame_len_i,
    output logic               bclk_o,
    output logic               lrclk_o
);

    logic [HP_W-1:0] period;
    logic slot0_hi;
    logic slot1_hi;
    logic fall0;
    logic fall1;
    logic lr0;
    logic lr1;
    logic b0_q;
    logic b1_q;
    logic l0_q;
    logic l1_q;

    // Decode the ratio selector into a half-cycle period.
    always_comb begin
        period = half_period(bclk_sel_i);
    end

    mcg_bit_phase #(.PW(HP_W)) u_phase (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (master_en_i),
        .period_i   (period),
        .slot0_hi_o (slot0_hi),
        .slot1_hi_o (slot1_hi),
        .fall0_o    (fall0),
        .fall1_o    (fall1)
    );

    mcg_frame_track #(.FW(FRAME_W)) u_frame (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (master_en_i),
        .len_i   (frame_len_i),
        .fall0_i (fall0),
        .fall1_i (fall1),
        .lr0_o   (lr0),
        .lr1_o   (lr1)
    );

    // Register both slot levels for the coming cycle; low when idle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !master_en_i) begin
            b0_q <= 1'b0;
            b1_q <= 1'b0;
            l0_q <= 1'b0;
            l1_q <= 1'b0;
        end else begin
            b0_q <= slot0_hi;
            b1_q <= slot1_hi;
            l0_q <= lr0;
            l1_q <= lr1;
        end
    end

    // Steer slot 0 to the pins while the clock is high, slot 1 while low.
    always_comb begin
        bclk_o  = clk_i ? b0_q : b1_q;
        lrclk_o = clk_i ? l0_q : l1_q;
    end

    // R1: a fresh enable starts with bit clock high and frame clock low.
    a_r1_restart_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(master_en_i) |=> (b0_q && !l0_q));

    // R6: a frame clock change at a cycle boundary needs a bit clock fall there.
    a_r6_lr_edge_slot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(master_en_i) && (l0_q != $past(l1_q))) |-> (!b0_q && $past(b1_q)));

    // R6: a frame clock change mid-cycle needs a bit clock fall there.
    a_r6_lr_edge_slot1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (l1_q != l0_q) |-> (b0_q && !b1_q));

    // R8: an invalid frame length keeps the frame clock low.
    a_r8_invalid_len_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (master_en_i && (frame_len_i < FRAME_W'(2))) |=> (!l0_q && !l1_q));

endmodule

// File: tb/mcg_master_clkgen_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected pin levels for each
// half-cycle; the monitor samples the pins in each half-cycle and compares.
module mcg_master_clkgen_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [3:0]  sel;
    logic [10:0] flen;
    logic        bclk;
    logic        lrclk;

    typedef struct {
        logic  b;
        logic  l;
        string tb;
        string tl;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    always #2.5 clk = ~clk;

    mcg_master_clkgen uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .master_en_i (en),
        .bclk_sel_i  (sel),
        .frame_len_i (flen),
        .bclk_o      (bclk),
        .lrclk_o     (lrclk)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic pop_cmp();
        if (q.size() > 0) begin
            exp_t e = q.pop_front();
            check(e.tb, bclk, e.b);
            check(e.tl, lrclk, e.l);
        end
    endtask

    // Monitor: one sample per half-cycle, away from the clock edges.
    initial begin
        forever begin
            @(posedge clk); #1; pop_cmp();
            @(negedge clk); #1; pop_cmp();
        end
    end

    // Ratio table from R2, expressed in half-cycles.
    function automatic int half_of(input int code);
        case (code)
            0: return 2;   1: return 3;   2: return 4;   3: return 6;
            4: return 8;   5: return 11;  6: return 12;  7: return 16;
            8: return 22;  9: return 24;  10: return 32; 11: return 44;
            12: return 48; 13: return 64; 14: return 88; default: return 96;
        endcase
    endfunction

    // Driver: disable, check idle pins, enable with a setting, queue the model.
    task automatic run_case(input int code, input int fl, input int nslots,
                            input string tb, input string tl);
        int t;
        int hi;
        int k;
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        q.push_back('{1'b0, 1'b0, "R1 disabled bclk", "R1 disabled lrclk"});
        en   = 1'b1;
        sel  = 4'(code);
        flen = 11'(fl);
        t  = half_of(code);
        hi = t / 2;
        k  = 0;
        for (int i = 0; i < nslots; i++) begin
            int   h;
            logic b;
            logic l;
            h = i % t;
            b = (h < hi);
            if (h == hi) k++;
            if (fl < 2 || k < 1) l = 1'b0;
            else l = (((k - 1) % fl) < (fl / 2));
            q.push_back('{b, l, tb, tl});
        end
        while (q.size() > 0) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #750000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        en    = 1'b1;
        sel   = 4'd0;
        flen  = 11'd4;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset bclk", bclk, 1'b0);
        check("R1 reset lrclk", lrclk, 1'b0);
        @(posedge clk); #1;
        check("R1 reset bclk high half", bclk, 1'b0);
        check("R1 reset lrclk high half", lrclk, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        run_case(0, 4, 30, "R2/R3 bclk /1", "R4/R5/R6/R7 lrclk L=4");
        run_case(1, 5, 45, "R3 bclk /1.5", "R5 odd lrclk L=5");
        run_case(5, 3, 80, "R3 bclk /5.5", "R5/R6 odd lrclk L=3");
        run_case(8, 2, 100, "R2 bclk /11", "R4/R7 lrclk L=2");
        run_case(15, 6, 1170, "R2 bclk /48", "R4/R6 lrclk L=6");
        run_case(2, 0, 60, "R8 bclk runs L=0", "R8 lrclk L=0");
        run_case(11, 1, 200, "R8 bclk runs L=1", "R8 lrclk L=1");
        run_case(7, 64, 2100, "R2 bclk /8", "R4 lrclk L=64");
        run_case(2, 2047, 16400, "R2 bclk /2", "R4/R5 lrclk L=2047");
        run_case(13, 32, 4200, "R2 bclk /32", "R4 lrclk L=32");
        for (int c = 3; c <= 14; c++) begin
            if (c != 5 && c != 7 && c != 8 && c != 11 && c != 13)
                run_case(c, 3, half_of(c) * 7 + 4, "R2/R3 bclk table", "R4/R5/R6 lrclk L=3");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule